// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical frame when the translation buffer has missed. On a start pulse it captures the address and the access type. It forms the address of the directory entry from the directory base input and the upper index field, then reads that entry through a single memory port. If the entry is usable, the walker reads the leaf entry from the page table it points to, using the middle index field. The result is a frame number with its writable and dirty bits, or a fault code.

When a write access hits a present, writable leaf entry whose dirty bit is still clear, the walker writes the entry back with the dirty bit set before it reports completion. The memory port uses a request/grant handshake. Read data comes back on a separate valid strobe after any number of cycles. A write is complete once it is granted and returns no response.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `mem_req_o` and `done_o` are all low.
- R2: The directory entry is read at `{dir_base_i, 12'h000} + 4*vaddr[31:22]`. The leaf entry is read at `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: While `mem_req_o` is high and `mem_gnt_i` is low, the request, its address and its write flag hold steady. Read data is taken in the cycle `mem_rvalid_i` is high, whatever the delay before it.
- R4: The entry layout is fixed. Bit 0 is present, bit 1 is writable (1 = read-write), bit 2 is dirty, bits 4:3 are the allocation status (2'b00 = unused, other values in use), and bits 31:12 are the frame number. Bits 11:5 are ignored.
- R5: A walk that succeeds ends with `done_o` high for exactly one cycle, `fault_o` = 0, `frame_o` = leaf bits 31:12, and `writable_o`/`dirty_o` showing the leaf's bits (dirty reads 1 after a dirty write-back).
- R6: A directory entry that is in use but not present ends the walk with `fault_o` = 1. No leaf read is issued.
- R7: A leaf entry that is in use but not present ends the walk with `fault_o` = 2.
- R8: An entry with status unused, at either level, ends the walk with `fault_o` = 3. This takes priority over its present bit. On any fault, `frame_o`, `writable_o` and `dirty_o` read 0.
- R9: A write access to a present leaf whose writable bit is 0 ends with `fault_o` = 3 and issues no memory write.
- R10: A write access to a present, writable leaf with a clear dirty bit issues exactly one write, to the leaf's address, with data equal to the leaf entry with bit 2 set. This write happens before `done_o`.
- R11: A read access, or a write access to a leaf that is already dirty, issues no memory write.
- R12: `start_i` is ignored whenever the walker is busy. Each accepted start yields exactly one `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| is_write_i | input | 1 | Access being translated is a write |
| dir_base_i | input | 20 | Frame number of the current directory |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Write data (entry with dirty bit set) |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | 0 none, 1 directory absent, 2 page absent, 3 protection |
| frame_o | output | 20 | Translated frame number |
| writable_o | output | 1 | Leaf writable bit |
| dirty_o | output | 1 | Leaf dirty bit after the walk |

## Verification
The bench targets index values 0 and 1023 at both levels. A wrong shift or base concatenation would fetch a neighbouring entry and return the wrong frame. It sets entries that are marked unused but have the present bit set; a design that checks present first would report a miss instead of a protection fault. It runs write accesses against clean, dirty and read-only leaves and counts the writes. A design that skips, repeats or misdirects the dirty write-back, or writes to a read-only page, changes both the count and the stored entry. Grant and read delays are stretched, and a second start arrives mid-walk. A walker that drops its request early or restarts would give a lost or duplicated completion.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_PTE_REQ,
        S_PTE_WAIT,
        S_DIRTY_WR,
        S_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_DIR_MISS  = 2'd1,
        FLT_PAGE_MISS = 2'd2,
        FLT_PROT      = 2'd3
    } fault_e;

    localparam int PRESENT_BIT   = 0;
    localparam int WRITABLE_BIT  = 1;
    localparam int DIRTY_BIT     = 2;
    localparam int STATUS_LO     = 3;
    localparam int STATUS_HI     = 4;
    localparam logic [1:0] STATUS_UNUSED = 2'b00;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int FRAME_W    = 20,
    parameter int OFF_W      = 12,
    parameter int IDX_W      = 10,
    parameter int ENT_LOG2   = 2
) (
    input  logic [FRAME_W-1:0]       base_frame_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [FRAME_W+OFF_W-1:0] addr_o
);
    localparam int PA_W = FRAME_W + OFF_W;

    logic [PA_W-1:0] base_addr;
    logic [PA_W-1:0] idx_off;

    always_comb begin
        base_addr = {base_frame_i, {OFF_W{1'b0}}};
        idx_off   = PA_W'({idx_i, {ENT_LOG2{1'b0}}});
        addr_o    = base_addr + idx_off;
    end
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
    import pt_walker_pkg::*;
#(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic               leaf_i,
    input  logic               write_i,
    output fault_e             fault_o,
    output logic               need_dirty_o
);
    logic [1:0] status;
    logic       present;
    logic       writable;
    logic       dirty;

    always_comb begin
        status       = entry_i[STATUS_HI:STATUS_LO];
        present      = entry_i[PRESENT_BIT];
        writable     = entry_i[WRITABLE_BIT];
        dirty        = entry_i[DIRTY_BIT];
        fault_o      = FLT_NONE;
        need_dirty_o = 1'b0;
        if (status == STATUS_UNUSED) begin
            fault_o = FLT_PROT;
        end else if (!present) begin
            fault_o = leaf_i ? FLT_PAGE_MISS : FLT_DIR_MISS;
        end else if (leaf_i && write_i && !writable) begin
            fault_o = FLT_PROT;
        end else begin
            need_dirty_o = leaf_i && write_i && !dirty;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10,
    parameter int ENT_LOG2  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [VA_W-1:0]            vaddr_i,
    input  logic                       is_write_i,
    input  logic [VA_W-DIR_IDX_W-TBL_IDX_W+DIR_IDX_W+TBL_IDX_W-(VA_W-DIR_IDX_W-TBL_IDX_W)-1:0] dir_base_i,
    output logic                       mem_req_o,
    output logic                       mem_we_o,
    output logic [VA_W-1:0]            mem_addr_o,
    output logic [VA_W-1:0]            mem_wdata_o,
    input  logic                       mem_gnt_i,
    input  logic                       mem_rvalid_i,
    input  logic [VA_W-1:0]            mem_rdata_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [1:0]                 fault_o,
    output logic [DIR_IDX_W+TBL_IDX_W-1:0] frame_o,
    output logic                       writable_o,
    output logic                       dirty_o
);
    localparam int OFF_W   = VA_W - DIR_IDX_W - TBL_IDX_W;
    localparam int FRAME_W = DIR_IDX_W + TBL_IDX_W;
    localparam int ENTRY_W = VA_W;
    localparam int PA_W    = FRAME_W + OFF_W;

    typedef struct packed {
        walk_st_e               st;
        logic                   wr;
        logic [TBL_IDX_W-1:0]   tbl_idx;
        logic [PA_W-1:0]        addr;
        logic [ENTRY_W-1:0]     entry;
        fault_e                 fault;
        logic [FRAME_W-1:0]     frame;
        logic                   writable;
        logic                   dirty;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [PA_W-1:0] dir_addr;
    logic [PA_W-1:0] pte_addr;
    fault_e          dec_fault;
    logic            dec_need_dirty;
    logic            at_leaf;

    pt_entry_addr #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W),
        .IDX_W   (DIR_IDX_W),
        .ENT_LOG2(ENT_LOG2)
    ) u_dir_addr (
        .base_frame_i(dir_base_i),
        .idx_i       (vaddr_i[VA_W-1 -: DIR_IDX_W]),
        .addr_o      (dir_addr)
    );

    pt_entry_addr #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W),
        .IDX_W   (TBL_IDX_W),
        .ENT_LOG2(ENT_LOG2)
    ) u_pte_addr (
        .base_frame_i(mem_rdata_i[ENTRY_W-1 -: FRAME_W]),
        .idx_i       (walk_q.tbl_idx),
        .addr_o      (pte_addr)
    );

    assign at_leaf = (walk_q.st == S_PTE_WAIT);

    pt_entry_decode #(
        .ENTRY_W(ENTRY_W)
    ) u_decode (
        .entry_i     (mem_rdata_i),
        .leaf_i      (at_leaf),
        .write_i     (walk_q.wr),
        .fault_o     (dec_fault),
        .need_dirty_o(dec_need_dirty)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            S_IDLE: begin
                if (start_i) begin
                    walk_d.st       = S_DIR_REQ;
                    walk_d.wr       = is_write_i;
                    walk_d.tbl_idx  = vaddr_i[OFF_W +: TBL_IDX_W];
                    walk_d.addr     = dir_addr;
                    walk_d.fault    = FLT_NONE;
                    walk_d.frame    = '0;
                    walk_d.writable = 1'b0;
                    walk_d.dirty    = 1'b0;
                end
            end
            S_DIR_REQ: begin
                if (mem_gnt_i) walk_d.st = S_DIR_WAIT;
            end
            S_DIR_WAIT: begin
                if (mem_rvalid_i) begin
                    if (dec_fault != FLT_NONE) begin
                        walk_d.fault = dec_fault;
                        walk_d.st    = S_DONE;
                    end else begin
                        walk_d.addr  = pte_addr;
                        walk_d.st    = S_PTE_REQ;
                    end
                end
            end
            S_PTE_REQ: begin
                if (mem_gnt_i) walk_d.st = S_PTE_WAIT;
            end
            S_PTE_WAIT: begin
                if (mem_rvalid_i) begin
                    if (dec_fault != FLT_NONE) begin
                        walk_d.fault = dec_fault;
                        walk_d.st    = S_DONE;
                    end else begin
                        walk_d.entry    = mem_rdata_i;
                        walk_d.frame    = mem_rdata_i[ENTRY_W-1 -: FRAME_W];
                        walk_d.writable = mem_rdata_i[WRITABLE_BIT];
                        walk_d.dirty    = mem_rdata_i[DIRTY_BIT] | dec_need_dirty;
                        if (dec_need_dirty) begin
                            walk_d.entry[DIRTY_BIT] = 1'b1;
                            walk_d.st = S_DIRTY_WR;
                        end else begin
                            walk_d.st = S_DONE;
                        end
                    end
                end
            end
            S_DIRTY_WR: begin
                if (mem_gnt_i) walk_d.st = S_DONE;
            end
            S_DONE: begin
                walk_d.st = S_IDLE;
            end
            default: begin
                walk_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    always_comb begin
        mem_req_o   = (walk_q.st == S_DIR_REQ) || (walk_q.st == S_PTE_REQ) ||
                      (walk_q.st == S_DIRTY_WR);
        mem_we_o    = (walk_q.st == S_DIRTY_WR);
        mem_addr_o  = walk_q.addr;
        mem_wdata_o = walk_q.entry;
        busy_o      = (walk_q.st != S_IDLE);
        done_o      = (walk_q.st == S_DONE);
        fault_o     = walk_q.fault;
        frame_o     = walk_q.frame;
        writable_o  = walk_q.writable;
        dirty_o     = walk_q.dirty;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R10
    dirty_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_wdata_o[DIRTY_BIT] && mem_wdata_o[WRITABLE_BIT] &&
                                     mem_wdata_o[PRESENT_BIT]));

    // R8
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != FLT_NONE) |-> (frame_o == '0 && !writable_o && !dirty_o));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic        is_write_i = 1'b0;
    logic [19:0] dir_base_i = 20'h00010;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        busy_o, done_o, writable_o, dirty_o;
    logic [1:0]  fault_o;
    logic [19:0] frame_o;

    always #10 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .is_write_i(is_write_i), .dir_base_i(dir_base_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
        .frame_o(frame_o), .writable_o(writable_o), .dirty_o(dirty_o)
    );

    typedef struct {
        logic [1:0]  fault;
        logic [19:0] frame;
        logic        wbl;
        logic        dty;
        int          reads;
        int          writes;
        logic [31:0] pte_a;
        logic        chk_mem;
        logic [31:0] mem_val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [logic [31:0]];
    int          rd_cnt = 0, wr_cnt = 0;
    int          gnt_dly = 0, rd_lat = 0;
    int          n_vec = 0, n_bad = 0;

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Entry layout (R4): [31:12] frame, [4:3] status (00 unused), [2] dirty, [1] writable, [0] present
    function automatic logic [31:0] mk(logic [19:0] fr, logic [1:0] st, logic d, logic w, logic p);
        return {fr, 7'b0, st, d, w, p};
    endfunction

    function automatic logic [31:0] diraddr(logic [31:0] va);
        return {dir_base_i, 12'h0} + {20'h0, va[31:22], 2'b00};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // independent walk model built from the requirements
    function automatic exp_t model(logic [31:0] va, logic wr, string tag);
        exp_t e;
        logic [31:0] de, pe;
        e = '{fault:0, frame:0, wbl:0, dty:0, reads:1, writes:0, pte_a:0,
              chk_mem:0, mem_val:0, tag:tag};
        de = rd(diraddr(va));
        if (de[4:3] == 2'b00) begin e.fault = 3; return e; end
        if (!de[0])           begin e.fault = 1; return e; end
        e.reads = 2;
        e.pte_a = {de[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        pe = rd(e.pte_a);
        if (pe[4:3] == 2'b00)   begin e.fault = 3; return e; end
        if (!pe[0])             begin e.fault = 2; return e; end
        if (wr && !pe[1])       begin e.fault = 3; e.chk_mem = 1; e.mem_val = pe; return e; end
        e.frame = pe[31:12];
        e.wbl = pe[1];
        e.dty = pe[2] | wr;
        e.writes = (wr && !pe[2]) ? 1 : 0;
        e.chk_mem = 1;
        e.mem_val = pe | (wr ? 32'h4 : 32'h0);
        return e;
    endfunction

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                logic [31:0] a, d;
                logic w;
                a = mem_addr_o; d = mem_wdata_o; w = mem_we_o;
                repeat (gnt_dly) @(negedge clk);
                mem_gnt_i = 1'b1;
                if (w) begin mem[a] = d; wr_cnt++; end
                else rd_cnt++;
                @(negedge clk);
                mem_gnt_i = 1'b0;
                if (!w) begin
                    repeat (rd_lat) @(negedge clk);
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = rd(a);
                    @(negedge clk);
                    mem_rvalid_i = 1'b0;
                    mem_rdata_i  = '0;
                end
            end
        end
    end

    // monitor: pop and compare on each completion
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R12 unexpected done: actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, "fault", 32'(fault_o), 32'(e.fault));
                    chk(e.tag, "frame", 32'(frame_o), 32'(e.frame));
                    chk(e.tag, "writable", 32'(writable_o), 32'(e.wbl));
                    chk(e.tag, "dirty", 32'(dirty_o), 32'(e.dty));
                    chk(e.tag, "reads (R2/R6)", 32'(rd_cnt), 32'(e.reads));
                    chk(e.tag, "writes (R10/R11)", 32'(wr_cnt), 32'(e.writes));
                    if (e.chk_mem) chk(e.tag, "stored entry", rd(e.pte_a), e.mem_val);
                end
            end
        end
    end

    task automatic walk(logic [31:0] va, logic wr, string tag);
        exp_q.push_back(model(va, wr, tag));
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        vaddr_i = va; is_write_i = wr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // directory at 0x10000; tables at frames 0x20, 0x21
        mem[32'h0001_0000 + 4*1]    = mk(20'h00020, 2'b01, 0, 1, 1);
        mem[32'h0001_0000 + 4*1023] = mk(20'h00021, 2'b10, 0, 1, 1);
        mem[32'h0001_0000 + 4*0]    = mk(20'h00022, 2'b01, 0, 1, 1);
        mem[32'h0001_0000 + 4*5]    = mk(20'h00033, 2'b01, 0, 0, 0); // absent dir
        mem[32'h0001_0000 + 4*6]    = mk(20'h00034, 2'b00, 0, 0, 1); // unused dir, present set
        mem[32'h0002_0000 + 4*3]    = mk(20'hABCDE, 2'b01, 0, 1, 1); // clean rw
        mem[32'h0002_0000 + 4*4]    = mk(20'h12345, 2'b11, 1, 1, 1); // dirty rw
        mem[32'h0002_0000 + 4*7]    = mk(20'h55555, 2'b01, 0, 0, 1); // read-only
        mem[32'h0002_0000 + 4*8]    = mk(20'h66666, 2'b01, 0, 1, 0); // absent page
        mem[32'h0002_0000 + 4*9]    = mk(20'h77777, 2'b00, 0, 1, 1); // unused page
        mem[32'h0002_1000 + 4*1023] = mk(20'hFEDCB, 2'b01, 0, 1, 1) | 32'h0000_0FE0;
        mem[32'h0002_2000 + 4*0]    = mk(20'h00ABC, 2'b01, 0, 1, 1);
        mem[32'h0002_0000 + 4*10]   = mk(20'h0F0F0, 2'b01, 0, 1, 1);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy_o), 0);
        chk("R1", "req", 32'(mem_req_o), 0);
        chk("R1", "done", 32'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        walk({10'd1, 10'd3, 12'h123}, 1'b0, "R5");        // read, clean
        walk({10'd1, 10'd3, 12'h000}, 1'b1, "R10");       // write, sets dirty
        walk({10'd1, 10'd3, 12'h000}, 1'b1, "R11");       // now dirty, no write
        walk({10'd1, 10'd4, 12'hFFF}, 1'b1, "R11");       // already dirty
        walk({10'd5, 10'd0, 12'h000}, 1'b0, "R6");        // directory absent
        walk({10'd1, 10'd8, 12'h000}, 1'b0, "R7");        // page absent
        walk({10'd6, 10'd0, 12'h000}, 1'b0, "R8");        // unused directory
        walk({10'd1, 10'd9, 12'h000}, 1'b0, "R8");        // unused page
        walk({10'd1, 10'd7, 12'h000}, 1'b1, "R9");        // write read-only
        walk({10'd1, 10'd7, 12'h000}, 1'b0, "R9");        // read read-only ok
        walk({10'd1023, 10'd1023, 12'hFFF}, 1'b0, "R2");  // top indices, junk bits 11:5 (R4)
        walk({10'd0, 10'd0, 12'h000}, 1'b0, "R2");        // zero indices
        walk({10'd3, 10'd3, 12'h000}, 1'b0, "R8");        // missing entry reads 0 = unused

        // R3 stretched handshake
        gnt_dly = 3; rd_lat = 4;
        walk({10'd1, 10'd10, 12'h000}, 1'b1, "R3");
        walk({10'd1023, 10'd1023, 12'h000}, 1'b0, "R3");

        // R12 start while busy is ignored
        exp_q.push_back(model({10'd1, 10'd4, 12'h0}, 1'b0, "R12"));
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        vaddr_i = {10'd1, 10'd4, 12'h0}; is_write_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        vaddr_i = {10'd5, 10'd0, 12'h0}; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R12", "busy after walk", 32'(busy_o), 0);
        chk("R12", "extra reads", 32'(rd_cnt), 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule